// File: doc/BRIEF.md
# Multi-Channel PWM Output Stage With Filtered Break Inputs

This block generates edge-aligned pulse-width-modulated waveforms on several channels from one shared time base. A prescaler divides the clock into ticks, and an up-counter counts those ticks from zero to a reload value. Every channel compares this common counter against its own compare value. A channel drives a main pin and a complementary pin. Each pin has its own enable and its own polarity. A master output enable gates every pin at once. While it is clear, each pin rests at its inactive level.

Software configures the block through a simple write port. The prescaler, the reload value and the compare values are written into preload registers. An update event moves them into the working registers. The counter wrapping produces an update event, and so does a software update command. The software update command also restarts the time base. For the reload value, a control bit selects between preloaded and immediate writes. Two break pins protect the load. Each break pin has its own enable, active level and consecutive-sample filter. A qualified break clears the master output enable at once, at any point in the period. The master output enable then stays clear until software sets it again after the break has ended.

The time base is a two-state machine: TB_STOP moves to TB_RUN on a control write with the run bit set, and TB_RUN moves back to TB_STOP on a control write with the run bit clear. Each break filter is a three-state machine. FLT_IDLE moves to FLT_QUAL on the first active sample, or straight to FLT_TRIP when the filter length is one. FLT_QUAL moves to FLT_TRIP when the required number of consecutive active samples has been seen, and back to FLT_IDLE on any inactive sample. FLT_TRIP moves back to FLT_IDLE on the first inactive sample.

Top module: `pwm_break_stage`

## Requirements
- R1: After reset the counter and prescaler are zero, the time base is stopped, the master output enable is clear, all channel and break configuration is zero, every pin is low and `brk_flag` is low.
- R2: Prescaler (address 1) and reload (address 2) are shared by all channels. Each counter period lasts (reload+1)*(prescaler+1) clocks. A prescaler write takes effect only at an update event. A control write (address 0) with bit 0 set starts counting and one with bit 0 clear stops it. A stopped counter holds its value.
- R3: Control bit 1 set makes a reload write wait in preload until the next update event. With bit 1 clear, a reload write takes effect at once.
- R4: A write to address 3 with bit 0 set is a software update: prescaler and counter restart from zero, and the preloaded prescaler, reload and all compare values become active in the same edge.
- R5: Channel k has its compare value at address 8+k, held in preload until an update event. Its internal reference is active while the counter is below the active compare value.
- R6: A compare value of 0 keeps the reference inactive for the whole period. A compare value above the reload value keeps it active for the whole period.
- R7: Address 4 holds one 4-bit field per channel, with channel k at bits 4k+3..4k: bit 0 main enable, bit 1 main polarity, bit 2 complementary enable, bit 3 complementary polarity. Each enabled pin drives its active level XOR its polarity bit. The complementary pin is active while the reference is inactive.
- R8: A pin drives its waveform only while the master output enable (address 5, bit 0) is set and its own enable is set. Otherwise it rests at its polarity bit.
- R9: Address 6 holds break k in bits 8k+5..8k: bit 0 enable, bit 1 active level (1 = high), bits 5..2 filter code F. A break qualifies after F+1 consecutive active samples of the synchronized pin. A shorter burst, or any activity on a disabled break, is ignored.
- R10: A qualified break clears the master output enable. The enable stays clear after the break ends until software sets it. A write that sets it while any break is qualified is ignored.
- R11: `brk_flag` is high exactly while at least one break is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| brk_in | input | 2 | Break pins, asynchronous |
| pwm_p | output | 4 | Main PWM pins, one per channel |
| pwm_n | output | 4 | Complementary PWM pins, one per channel |
| brk_flag | output | 1 | High while any break is qualified |

## Verification
The main waveform is measured by counting the high cycles over windows that are whole multiples of the period. Compare values of zero, inside the period and beyond the reload value separate the normal duty case from the two saturated ones. Swapping polarity bits and reading the complementary pin confirms that each pin inverts on its own. A changed count under a larger prescaler shows that the period scales. Starting the counter from a known restart with a shortened reload, once with preload on and once with it off, tells deferred loading apart from immediate loading. On the break side, a burst one sample short of the filter length is compared with one that is long enough, and an active-low break is tried. Writes that try to set the enable during a break are shown to be ignored, and a disabled break is shown to have no effect.

// File: rtl/pwm_brk_pkg.sv
`timescale 1ns/1ps
package pwm_brk_pkg;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_PSC    = 4'd1;
    localparam logic [3:0] A_RELOAD = 4'd2;
    localparam logic [3:0] A_UPDATE = 4'd3;
    localparam logic [3:0] A_CHCFG  = 4'd4;
    localparam logic [3:0] A_MOE    = 4'd5;
    localparam logic [3:0] A_BRKCFG = 4'd6;
    localparam logic [3:0] A_CMP0   = 4'd8;

    typedef enum logic {
        TB_STOP,
        TB_RUN
    } tb_state_e;

    typedef enum logic [1:0] {
        FLT_IDLE,
        FLT_QUAL,
        FLT_TRIP
    } flt_state_e;

    // per-channel field: bit0 main enable, bit1 main polarity,
    // bit2 complementary enable, bit3 complementary polarity
    typedef struct packed {
        logic cpol;
        logic cen;
        logic pol;
        logic en;
    } ch_cfg_t;

    // per-break field: bit0 enable, bit1 active level, bits5..2 filter code
    typedef struct packed {
        logic [3:0] code;
        logic       level;
        logic       en;
    } brk_cfg_t;

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm_brk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_wr,
    input  logic          run_val,
    input  logic          arpe,
    input  logic          psc_wr,
    input  logic          arr_wr,
    input  logic [CW-1:0] wr_val,
    input  logic          sw_upd,
    output logic [CW-1:0] cnt,
    output logic          upd
);

    tb_state_e     st_q, st_d;
    logic [CW-1:0] psc_pre, psc_act;
    logic [CW-1:0] arr_pre, arr_act;
    logic [CW-1:0] pcnt_q, cnt_q;
    logic          tick, wrap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TB_STOP;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TB_STOP: if (run_wr && run_val)  st_d = TB_RUN;
            TB_RUN:  if (run_wr && !run_val) st_d = TB_STOP;
            default: st_d = TB_STOP;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        tick = (st_q == TB_RUN) && (pcnt_q >= psc_act);
        wrap = tick && (cnt_q >= arr_act);
        upd  = sw_upd || wrap;
        cnt  = cnt_q;
    end

    // prescaler and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else if (sw_upd) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else if (st_q == TB_RUN) begin
            if (tick) begin
                pcnt_q <= '0;
                cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // preload and active copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_pre <= '0;
            psc_act <= '0;
            arr_pre <= '1;
            arr_act <= '1;
        end else begin
            if (psc_wr) psc_pre <= wr_val;
            if (arr_wr) arr_pre <= wr_val;
            if (upd) begin
                psc_act <= psc_pre;
                arr_act <= arr_pre;
            end
            if (arr_wr && !arpe) arr_act <= wr_val;
        end
    end

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TB_STOP && !sw_upd) |=> $stable(cnt_q));

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !sw_upd) |=> (cnt_q == '0));

    assert_sw_update_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd && !psc_wr) |=> (psc_act == $past(psc_pre) && pcnt_q == '0));

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_brk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_wr,
    input  logic [CW-1:0] wr_val,
    input  logic          upd,
    input  logic [CW-1:0] cnt,
    input  ch_cfg_t       cfg,
    input  logic          moe,
    output logic          pin_p,
    output logic          pin_n
);

    logic [CW-1:0] cmp_pre, cmp_act;
    logic          ref_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_pre <= '0;
            cmp_act <= '0;
        end else begin
            if (cmp_wr) cmp_pre <= wr_val;
            if (upd)    cmp_act <= cmp_pre;
        end
    end

    always_comb begin
        ref_act = (cnt < cmp_act);
        pin_p   = (moe && cfg.en)  ? (ref_act ^ cfg.pol)   : cfg.pol;
        pin_n   = (moe && cfg.cen) ? (!ref_act ^ cfg.cpol) : cfg.cpol;
    end

    assert_zero_compare_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |-> (pin_p == cfg.pol));

    assert_gated_pins_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !moe |-> (pin_p == cfg.pol && pin_n == cfg.cpol));

    assert_pins_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (moe && cfg.en && cfg.cen && cfg.pol == cfg.cpol) |-> (pin_p != pin_n));

endmodule

// File: rtl/pwm_break_filter.sv
`timescale 1ns/1ps
module pwm_break_filter
    import pwm_brk_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  brk_cfg_t cfg,
    output logic     trip
);

    logic         s1_q, s2_q;
    logic         act;
    logic [FW:0]  need;
    logic [FW:0]  seen_q;
    flt_state_e   st_q, st_d;

    // two-stage synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
        end
    end

    assign act  = cfg.en && (s2_q == cfg.level);
    assign need = {1'b0, cfg.code} + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLT_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLT_IDLE: if (act) st_d = (need == 1) ? FLT_TRIP : FLT_QUAL;
            FLT_QUAL: if (!act) st_d = FLT_IDLE;
                      else if (seen_q + 1'b1 >= need) st_d = FLT_TRIP;
            FLT_TRIP: if (!act) st_d = FLT_IDLE;
            default:  st_d = FLT_IDLE;
        endcase
    end

    // consecutive-sample counter
    always_ff @(posedge clk) begin
        if (!rst_n)                         seen_q <= '0;
        else if (st_q == FLT_IDLE && act)   seen_q <= 1;
        else if (st_q == FLT_QUAL && act)   seen_q <= seen_q + 1'b1;
        else                                seen_q <= '0;
    end

    // outputs
    always_comb begin
        trip = (st_q == FLT_TRIP);
    end

    assert_trip_needs_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_TRIP) |-> $past(act));

    assert_disabled_never_trips_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (st_q != FLT_TRIP));

endmodule

// File: rtl/pwm_break_stage.sv
`timescale 1ns/1ps
module pwm_break_stage
    import pwm_brk_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CW   = 16,
    parameter int DW   = 16,
    parameter int NBRK = 2,
    parameter int FW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NBRK-1:0] brk_in,
    output logic [NCH-1:0]  pwm_p,
    output logic [NCH-1:0]  pwm_n,
    output logic          brk_flag
);

    localparam int CFG_W = $bits(ch_cfg_t);
    localparam int BRK_W = $bits(brk_cfg_t);
    localparam int BRK_STRIDE = 8;

    logic            arpe_q;
    logic            moe_q;
    ch_cfg_t         ch_cfg_q  [NCH];
    brk_cfg_t        brk_cfg_q [NBRK];
    logic [NBRK-1:0] trip_v;
    logic            any_trip;
    logic [CW-1:0]   cnt;
    logic            upd;
    logic            run_wr, psc_wr, arr_wr, sw_upd, moe_wr, chcfg_wr, brkcfg_wr;

    always_comb begin
        run_wr    = wr_en && (wr_addr == A_CTRL);
        psc_wr    = wr_en && (wr_addr == A_PSC);
        arr_wr    = wr_en && (wr_addr == A_RELOAD);
        sw_upd    = wr_en && (wr_addr == A_UPDATE) && wr_data[0];
        chcfg_wr  = wr_en && (wr_addr == A_CHCFG);
        moe_wr    = wr_en && (wr_addr == A_MOE);
        brkcfg_wr = wr_en && (wr_addr == A_BRKCFG);
        any_trip  = |trip_v;
        brk_flag  = any_trip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      arpe_q <= 1'b0;
        else if (run_wr) arpe_q <= wr_data[1];
    end

    // master output enable: cleared by any qualified break, set only by software
    always_ff @(posedge clk) begin
        if (!rst_n)        moe_q <= 1'b0;
        else if (any_trip) moe_q <= 1'b0;
        else if (moe_wr)   moe_q <= wr_data[0];
    end

    pwm_timebase #(.CW(CW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_wr  (run_wr),
        .run_val (wr_data[0]),
        .arpe    (arpe_q),
        .psc_wr  (psc_wr),
        .arr_wr  (arr_wr),
        .wr_val  (wr_data[CW-1:0]),
        .sw_upd  (sw_upd),
        .cnt     (cnt),
        .upd     (upd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)        ch_cfg_q[g] <= '0;
            else if (chcfg_wr) ch_cfg_q[g] <= ch_cfg_t'(wr_data[CFG_W*g +: CFG_W]);
        end

        pwm_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmp_wr (wr_en && (wr_addr == A_CMP0 + 4'(g))),
            .wr_val (wr_data[CW-1:0]),
            .upd    (upd),
            .cnt    (cnt),
            .cfg    (ch_cfg_q[g]),
            .moe    (moe_q),
            .pin_p  (pwm_p[g]),
            .pin_n  (pwm_n[g])
        );
    end

    for (genvar b = 0; b < NBRK; b++) begin : g_brk
        always_ff @(posedge clk) begin
            if (!rst_n)         brk_cfg_q[b] <= '0;
            else if (brkcfg_wr) brk_cfg_q[b] <= brk_cfg_t'(wr_data[BRK_STRIDE*b +: BRK_W]);
        end

        pwm_break_filter #(.FW(FW)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (brk_in[b]),
            .cfg   (brk_cfg_q[b]),
            .trip  (trip_v[b])
        );
    end

    assert_trip_clears_moe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_trip |=> !moe_q);

    assert_moe_set_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moe_q) |-> $past(moe_wr && wr_data[0] && !any_trip));

    assert_flag_tracks_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag |=> !moe_q);

endmodule

// File: tb/pwm_break_stage_tb_top.sv
`timescale 1ns/1ps
module pwm_break_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  brk_in = 2'b10;
    logic [3:0]  pwm_p, pwm_n;
    logic        brk_flag;

    always #2.5 clk = ~clk;

    pwm_break_stage dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .brk_in   (brk_in),
        .pwm_p    (pwm_p),
        .pwm_n    (pwm_n),
        .brk_flag (brk_flag)
    );

    typedef struct {
        string req;
        int    sel;
        int    win;
        int    exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int pushed = 0;
    int popped = 0;
    int n_chk  = 0;
    int n_err  = 0;
    bit finished = 0;

    function automatic logic pick(int s);
        if (s < 4)      return pwm_p[s];
        else if (s < 8) return pwm_n[s-4];
        else            return brk_flag;
    endfunction

    // monitor: count high cycles of the chosen output and compare
    initial begin
        forever begin
            sb_item_t it;
            int hi;
            wait (pushed > popped);
            it = sb_q.pop_front();
            hi = 0;
            for (int i = 0; i < it.win; i++) begin
                #1;
                if (pick(it.sel)) hi++;
                @(negedge clk);
            end
            n_chk++;
            if (hi != it.exp) begin
                n_err++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, hi, it.exp);
            end
            popped++;
        end
    end

    // driver: expect() pushes an item and waits for the monitor
    task automatic expect_hi(string req, int sel, int win, int exp);
        sb_item_t it;
        it.req = req; it.sel = sel; it.win = win; it.exp = exp;
        sb_q.push_back(it);
        pushed++;
        wait (popped == pushed);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        expect_hi("R1 main pins", 0, 4, 0);
        expect_hi("R1 comp pins", 4, 4, 0);
        expect_hi("R1 brk_flag", 8, 4, 0);

        // shared time base: reload 9, prescaler 0
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'd9);
        wr(4'd1, 16'd0);
        wr(4'd8, 16'd3);
        wr(4'd9, 16'd0);
        wr(4'd10, 16'd15);
        wr(4'd11, 16'd5);
        wr(4'd4, 16'h2115);
        wr(4'd3, 16'h0001);
        wr(4'd5, 16'h0001);
        wr(4'd0, 16'h0001);
        idle(2);
        expect_hi("R5 duty 3 of 10", 0, 20, 6);
        expect_hi("R6 compare zero", 1, 20, 0);
        expect_hi("R6 compare above reload", 2, 20, 20);
        expect_hi("R7 complementary", 4, 20, 14);
        expect_hi("R8 disabled channel rests at polarity", 3, 10, 10);

        // R7 polarity inversion on both pins
        wr(4'd4, 16'h211F);
        idle(1);
        expect_hi("R7 main inverted", 0, 20, 14);
        expect_hi("R7 comp inverted", 4, 20, 6);
        wr(4'd4, 16'h2115);

        // R3 reload preload on: first period keeps reload 9
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0002);
        wr(4'd2, 16'd2);
        wr(4'd0, 16'h0003);
        expect_hi("R3 preloaded reload deferred", 0, 10, 3);
        // R3 reload preload off: short reload at once
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'd9);
        wr(4'd3, 16'h0001);
        wr(4'd2, 16'd2);
        wr(4'd0, 16'h0001);
        expect_hi("R3 immediate reload", 0, 10, 10);
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'd9);
        wr(4'd3, 16'h0001);

        // R4/R5 compare preload and software update, counter stopped at 0
        wr(4'd8, 16'd0);
        expect_hi("R5 compare held in preload", 0, 4, 4);
        wr(4'd3, 16'h0001);
        expect_hi("R4 update loads compare", 0, 4, 0);
        wr(4'd8, 16'd3);
        wr(4'd3, 16'h0001);

        // R2 prescaler 1 doubles the period
        wr(4'd1, 16'd1);
        expect_hi("R2 prescaler preloaded, stopped counter", 0, 4, 4);
        wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0001);
        expect_hi("R2 prescaled duty", 0, 40, 12);
        expect_hi("R2 prescaled comp", 4, 40, 28);
        wr(4'd1, 16'd0);
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0001);

        // R9 break 0: enabled, active high, code 3 -> 4 samples
        wr(4'd6, 16'h000F);
        brk_in[0] = 1'b1;
        idle(3);
        brk_in[0] = 1'b0;
        idle(6);
        expect_hi("R9 short burst ignored flag", 8, 1, 0);
        expect_hi("R9 short burst ignored pins", 0, 20, 6);
        brk_in[0] = 1'b1;
        idle(8);
        expect_hi("R11 flag during break", 8, 1, 1);
        expect_hi("R10 main idle during break", 0, 20, 0);
        expect_hi("R10 comp idle during break", 4, 20, 0);
        brk_in[0] = 1'b0;
        idle(5);
        expect_hi("R11 flag after break", 8, 1, 0);
        expect_hi("R10 enable stays clear", 0, 20, 0);
        wr(4'd5, 16'h0001);
        expect_hi("R10 software re-enable", 0, 20, 6);

        // R9 break 1 active low, code 0; R10 write during break ignored
        wr(4'd6, 16'h010F);
        brk_in[1] = 1'b0;
        idle(5);
        expect_hi("R9 active-low break flag", 8, 1, 1);
        wr(4'd5, 16'h0001);
        brk_in[1] = 1'b1;
        idle(5);
        expect_hi("R10 set during break ignored", 0, 20, 0);
        wr(4'd5, 16'h0001);
        expect_hi("R10 re-enable after break", 0, 20, 6);

        // R9 disabled break has no effect
        wr(4'd6, 16'h0000);
        brk_in[0] = 1'b1;
        idle(10);
        expect_hi("R9 disabled break flag", 8, 1, 0);
        expect_hi("R9 disabled break pins", 0, 20, 6);
        brk_in[0] = 1'b0;

        // R8 master enable cleared by software
        wr(4'd5, 16'h0000);
        expect_hi("R8 gated main", 0, 20, 0);
        expect_hi("R8 gated polarity rest", 3, 10, 10);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule